// File: doc/BRIEF.md
# Hardware Monitor Control Sequencer

This block is the control core of a system-health monitor. A small register bus writes a configuration register. That register starts and stops a round-robin measurement loop, gates and clears the interrupt output, launches a timed reset pulse, clears an intrusion latch and triggers a soft initialization. The loop asks an external converter for one channel at a time. It issues a one-cycle start with a channel index and waits for a done strobe. The seven channels are visited in a fixed order: CPU core 2, +12 V, +5 V, +3.3 V, +2.5 V, CPU core 1, and temperature last.

A separate test register holds a full-shutdown bit. Setting it switches off the analog output level and lets any running conversion finish, but it keeps every register. Clearing the bit brings the block back to where it was. The interrupt source and the intrusion event arrive as raw input pulses and are latched inside the block.

Top module: `hwmon_ctrl`

## Requirements
- R1: After reset the control register (address 0x40) reads 0x08, which has the interrupt-clear bit 3 set. The interrupt, intrusion, reset-pulse, converter-enable and converter-start outputs are all 0.
- R2: The loop runs while control bit 0 is 1, bit 3 is 0 and test bit 0 is 0. Each start carries a channel code from 0 to 6, in the order given above, and the code wraps from 6 back to 0. Each new start follows the previous done. `adc_en_o` is 1 exactly when bit 0 is 1 and test bit 0 is 0.
- R3: The interrupt status bit (bit 0 at 0x41) latches a cycle of `irq_src_i` and is cleared by a read of 0x41. `irq_o` is 1 only while status is set, control bit 1 is 1 and bit 3 is 0.
- R4: Control bit 3 forces `irq_o` to 0 and halts the loop until the bit returns to 0. It leaves the status bit unchanged.
- R5: When the loop is halted in the middle of a pass, the current conversion completes and `conv_chan_o` keeps that channel. The next start after a restart carries channel 0.
- R6: A write of 1 to control bit 4, made while bit 7 of register 0x44 is 1, drives `rst_pulse_o` high for exactly RST_CYC cycles. With that bit at 0 the write has no effect. A write made during a pulse does not extend it.
- R7: `ci_event_i` sets `ci_o`. While control bit 6 is 1, `ci_o` is held at 0.
- R8: A write with control bit 7 set restores the control register (reads 0x08), register 0x44 (0x00), the status bit and the intrusion latch. It keeps the test register (0x15) and the analog-output register (0x19). Bit 7 never reads back as 1.
- R9: Test bit 0 set to 1 drives `aout_o` and `adc_en_o` to 0 and stops new starts, and it keeps all register contents. Clearing the bit restores `aout_o` to the register value and resumes the loop at channel 0.
- R10: Registers 0x40, 0x44, 0x15 and 0x19 read back what was written. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status on 0x41) |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq_src_i | input | 1 | Raw interrupt source |
| ci_event_i | input | 1 | Chassis intrusion event |
| irq_o | output | 1 | Interrupt output, active high |
| ci_o | output | 1 | Intrusion latch output |
| rst_pulse_o | output | 1 | Timed reset pulse |
| adc_en_o | output | 1 | Converter enable (0 in low power) |
| aout_o | output | 8 | Analog-output level |
| conv_start_o | output | 1 | One-cycle conversion request |
| conv_chan_o | output | 3 | Channel code of the request |
| conv_done_i | input | 1 | Conversion complete strobe |

## Verification
The checks assume that `conv_done_i` is a single-cycle strobe, raised only while a conversion is outstanding, some cycles after its start. The converter model in the stimulus keeps to this: it answers each start exactly once and can hold its answer back to freeze the loop in the middle of a pass. The checks also assume that a read and a write never occur in the same cycle, and the register tasks drive only one strobe at a time.

// File: rtl/hwmon_ctrl.sv
module hwmon_ctrl #(
  parameter int DW     = 8,
  parameter int AW     = 8,
  parameter int RST_CYC = 5_000_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          irq_src_i,
  input  logic          ci_event_i,
  output logic          irq_o,
  output logic          ci_o,
  output logic          rst_pulse_o,
  output logic          adc_en_o,
  output logic [DW-1:0] aout_o,
  output logic          conv_start_o,
  output logic [2:0]    conv_chan_o,
  input  logic          conv_done_i
);
  localparam int NUM_CH = 7;
  localparam int CW     = $clog2(RST_CYC + 1);
  localparam logic [AW-1:0] A_CFG  = AW'(8'h40);
  localparam logic [AW-1:0] A_STAT = AW'(8'h41);
  localparam logic [AW-1:0] A_RCTL = AW'(8'h44);
  localparam logic [AW-1:0] A_TEST = AW'(8'h15);
  localparam logic [AW-1:0] A_AOUT = AW'(8'h19);
  localparam logic [DW-1:0] CFG_RST = DW'(8'h08);

  logic [DW-1:0] cfg_q, rstctl_q, test_q, aout_q;
  logic          stat_q, ci_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, fresh_q, start_q;
  logic [2:0]    idx_q;

  wire wr_cfg  = bus_wr && bus_addr == A_CFG;
  wire init_w  = wr_cfg && bus_wdata[7];
  wire rd_stat = bus_rd && bus_addr == A_STAT;
  wire trig    = wr_cfg && bus_wdata[4] && !bus_wdata[7] && rstctl_q[7] && cnt_q == '0;
  wire run     = cfg_q[0] && !cfg_q[3] && !test_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST; rstctl_q <= '0; test_q <= '0; aout_q <= '0;
      stat_q <= 1'b0; ci_q <= 1'b0;
    end else begin
      if (init_w) begin
        cfg_q <= CFG_RST; rstctl_q <= '0; stat_q <= 1'b0; ci_q <= 1'b0;
      end else begin
        if (wr_cfg) cfg_q <= bus_wdata;
        if (bus_wr && bus_addr == A_RCTL) rstctl_q <= bus_wdata;
        stat_q <= (stat_q && !rd_stat) || irq_src_i;
        ci_q   <= cfg_q[6] ? 1'b0 : (ci_q || ci_event_i);
      end
      if (bus_wr && bus_addr == A_TEST) test_q <= bus_wdata;
      if (bus_wr && bus_addr == A_AOUT) aout_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (trig)        cnt_q <= CW'(RST_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; fresh_q <= 1'b1; start_q <= 1'b0; idx_q <= '0;
    end else begin
      start_q <= 1'b0;
      if (!busy_q && run) begin
        start_q <= 1'b1;
        busy_q  <= 1'b1;
        fresh_q <= 1'b0;
        if (fresh_q) idx_q <= '0;
      end else if (busy_q && conv_done_i) begin
        busy_q <= 1'b0;
        if (run) idx_q <= (idx_q == 3'(NUM_CH - 1)) ? '0 : idx_q + 1'b1;
        else     fresh_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = cfg_q;
      A_STAT:  bus_rdata = DW'(stat_q);
      A_RCTL:  bus_rdata = rstctl_q;
      A_TEST:  bus_rdata = test_q;
      A_AOUT:  bus_rdata = aout_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o        = stat_q && cfg_q[1] && !cfg_q[3];
  assign ci_o         = ci_q;
  assign rst_pulse_o  = cnt_q != '0;
  assign adc_en_o     = cfg_q[0] && !test_q[0];
  assign aout_o       = test_q[0] ? '0 : aout_q;
  assign conv_start_o = start_q;
  assign conv_chan_o  = idx_q;
endmodule

// File: rtl/hwmon_ctrl_chk.sv
module hwmon_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_start_o,
  input logic          conv_done_i,
  input logic [2:0]    conv_chan_o,
  input logic          adc_en_o,
  input logic          ci_o,
  input logic          rst_pulse_o,
  input logic [DW-1:0] cfg_q,
  input logic [DW-1:0] test_q,
  input logic [DW-1:0] rstctl_q
);
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);

  a_r2_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_en_o && $past(!adc_en_o)) |-> !conv_start_o);

  a_r5_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done_i |=> (conv_start_o || $stable(conv_chan_o)));

  a_r6_pulse_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse_o) |-> $past(rstctl_q[7]));

  a_r7_ci_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[6] |=> !ci_o);

  a_r9_shutdown_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (test_q[0] && $past(test_q[0])) |-> !conv_start_o);

  a_r8_init_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_q[7]) |-> !cfg_q[7]);
endmodule

bind hwmon_ctrl hwmon_ctrl_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .conv_start_o(conv_start_o), .conv_done_i(conv_done_i),
  .conv_chan_o(conv_chan_o), .adc_en_o(adc_en_o), .ci_o(ci_o), .rst_pulse_o(rst_pulse_o),
  .cfg_q(cfg_q), .test_q(test_q), .rstctl_q(rstctl_q)
);

// File: tb/hwmon_ctrl_tb_top.sv
`timescale 1ns/1ps
module hwmon_ctrl_tb_top;
  localparam int PULSE = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0, irq_src = 0, ci_ev = 0, conv_done = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata, aout;
  logic irq, ci, rst_pulse, adc_en, conv_start;
  logic [2:0] conv_chan;
  int checks = 0, fails = 0, pulse_cycles = 0;
  logic stall = 0;
  logic [2:0] exp_q[$];
  logic [7:0] rv;

  always #2 clk = ~clk;

  hwmon_ctrl #(.RST_CYC(PULSE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src_i(irq_src), .ci_event_i(ci_ev),
    .irq_o(irq), .ci_o(ci), .rst_pulse_o(rst_pulse), .adc_en_o(adc_en), .aout_o(aout),
    .conv_start_o(conv_start), .conv_chan_o(conv_chan), .conv_done_i(conv_done));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic push(logic [2:0] c);
    exp_q.push_back(c);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq_src = 1; @(negedge clk); irq_src = 0;
  endtask

  task automatic pulse_ci();
    @(negedge clk); ci_ev = 1; @(negedge clk); ci_ev = 0;
  endtask

  // monitor and converter model: compares each start against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (conv_start) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R2: actual unexpected start chan %0d expected none", conv_chan);
        end else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          if (e !== conv_chan) begin
            fails++;
            $display("FAIL R2: actual chan %0d expected %0d", conv_chan, e);
          end
          if (exp_q.size() == 0) stall = 1;
        end
        @(negedge clk); @(negedge clk);
        while (stall) @(negedge clk);
        conv_done = 1; @(negedge clk); conv_done = 0;
      end
    end
  end

  always @(negedge clk) if (rst_pulse) pulse_cycles++;

  initial begin
    #(4 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    rd(8'h40, rv); chk("R1 cfg", rv, 8'h08);
    chk("R1 irq", irq, 0); chk("R1 ci", ci, 0); chk("R1 pulse", rst_pulse, 0);
    chk("R1 adc_en", adc_en, 0); chk("R1 start", conv_start, 0);
    // R10 readback
    wr(8'h19, 8'h5A); rd(8'h19, rv); chk("R10 aout reg", rv, 8'h5A);
    wr(8'h44, 8'h80); rd(8'h44, rv); chk("R10 rstctl", rv, 8'h80);
    wr(8'h44, 8'h00);
    rd(8'h33, rv); chk("R10 unmapped", rv, 8'h00);
    chk("R9 aout on", aout, 8'h5A);

    // R2 order and wrap, stall on channel 1
    for (int i = 0; i < 7; i++) push(3'(i));
    push(0); push(1);
    wr(8'h40, 8'h03);
    chk("R2 adc_en", adc_en, 1);
    drain();
    chk("R5 chan mid", conv_chan, 1);
    // R5 stop mid-pass
    wr(8'h40, 8'h02);
    chk("R2 low power adc_en", adc_en, 0);
    stall = 0;
    repeat (20) @(negedge clk);
    chk("R5 chan held", conv_chan, 1);
    rd(8'h40, rv); chk("R2 bus alive in low power", rv, 8'h02);
    push(0); push(1); push(2);
    wr(8'h40, 8'h03);
    drain();

    // R3 / R4 interrupts
    pulse_irq();
    chk("R3 irq set", irq, 1);
    wr(8'h40, 8'h0B);
    chk("R4 irq cleared", irq, 0);
    stall = 0;
    repeat (20) @(negedge clk);
    chk("R4 paused chan", conv_chan, 2);
    push(0);
    wr(8'h40, 8'h03);
    chk("R4 status kept", irq, 1);
    drain();
    rd(8'h41, rv); chk("R3 status bit", rv, 8'h01);
    chk("R3 read clears", irq, 0);
    wr(8'h40, 8'h01);
    pulse_irq();
    chk("R3 disabled", irq, 0);
    rd(8'h41, rv); chk("R3 status latched", rv, 8'h01);

    // R9 shutdown
    wr(8'h15, 8'h01);
    chk("R9 aout off", aout, 8'h00);
    chk("R9 adc_en off", adc_en, 0);
    stall = 0;
    repeat (20) @(negedge clk);
    rd(8'h19, rv); chk("R9 aout kept", rv, 8'h5A);
    rd(8'h40, rv); chk("R9 cfg kept", rv, 8'h01);
    push(0);
    wr(8'h15, 8'h00);
    chk("R9 aout back", aout, 8'h5A);
    chk("R9 adc_en back", adc_en, 1);
    drain();

    // R6 reset pulse
    wr(8'h40, 8'h11);
    repeat (5) begin @(negedge clk); chk("R6 no enable", rst_pulse, 0); end
    wr(8'h44, 8'h80);
    pulse_cycles = 0;
    wr(8'h40, 8'h11);
    chk("R6 pulse high", rst_pulse, 1);
    repeat (3) @(negedge clk);
    wr(8'h40, 8'h11);
    repeat (30) @(negedge clk);
    chk("R6 pulse length", 8'(pulse_cycles), 8'(PULSE));

    // R7 intrusion latch
    pulse_ci();
    chk("R7 ci set", ci, 1);
    wr(8'h40, 8'h41);
    @(negedge clk);
    chk("R7 ci cleared", ci, 0);
    pulse_ci();
    @(negedge clk);
    chk("R7 ci held clear", ci, 0);
    wr(8'h40, 8'h01);
    pulse_ci();
    chk("R7 ci set again", ci, 1);

    // R8 soft init
    wr(8'h44, 8'h80);
    wr(8'h15, 8'h40);
    pulse_irq();
    wr(8'h40, 8'h80);
    stall = 0;
    repeat (20) @(negedge clk);
    rd(8'h40, rv); chk("R8 cfg", rv, 8'h08);
    rd(8'h44, rv); chk("R8 rstctl", rv, 8'h00);
    rd(8'h41, rv); chk("R8 status", rv, 8'h00);
    chk("R8 ci", ci, 0);
    rd(8'h15, rv); chk("R8 test kept", rv, 8'h40);
    rd(8'h19, rv); chk("R8 aout kept", rv, 8'h5A);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule